// File: doc/BRIEF.md
# USB Full-Speed Packet Receiver

This block turns the differential line state delivered by an external full-speed USB transceiver into validated packets in the system clock domain. The line is oversampled at four times the bit rate. A small clock-recovery state machine re-centres its sampling point on every line transition and decodes NRZI as it samples. A bit-level stage then finds the sync pattern, strips stuffed bits, watches for stuffing violations and detects the end-of-packet signalling. A packet stage assembles bytes least significant bit first, validates and classifies the packet identifier, and runs both CRCs.

Token packets are collected in a staging register. They reach the live token outputs only once their 5-bit CRC and length check out. Data payload bytes are written out as they arrive, two bytes behind the wire, so that the trailing CRC16 bytes are never written. The packet is then judged by the CRC16 verdict at end of packet. Every accepted packet produces one status pulse carrying its kind, its PID and a CRC error flag. Packets with a malformed PID, packets seen while the local transmitter is active, and packets aborted by a stuffing error produce no status pulse.

Top module: `usb_fs_rx`

## Requirements
- R1: After reset, all strobes (`tok_valid_o`, `data_we_o`, `pkt_done_o`) are low and the token, data and status outputs are zero.
- R2: Line state is J when dp=1, dm=0, K when dp=0, dm=1, and SE0 when both are 0. One bit lasts `OVS` (default 4) clocks. The sampling phase restarts on every line change, so a stream in which every eighth bit is stretched by one clock still decodes correctly.
- R3: A bit is 0 when the sampled level differs from the previous bit's level and 1 when it is the same. A packet starts when at least five 0 bits are followed by a 1, as the sync pattern KJKJKJKK does.
- R4: After six consecutive 1 bits, the next bit is removed. If that bit is a 1, the packet is aborted: no status pulse is raised and the token outputs are unchanged.
- R5: A packet ends on SE0 followed by a non-SE0 sample, and an accepted packet raises `pkt_done_o` for exactly one cycle.
- R6: The first byte after sync is the PID, sent LSB first. It is accepted only if bits [7:4] are the bitwise complement of bits [3:0]. Otherwise no status pulse and no data write occur for that packet.
- R7: `pkt_kind_o` equals PID bits [1:0]: 2'b01 token, 2'b11 data, 2'b10 handshake. Kind 2'b00 is dropped. `pkt_pid_o` carries PID bits [3:0]. A handshake reports no CRC error when it is exactly one byte long.
- R8: A token carries 7 address bits, then 4 endpoint bits, then a CRC5 (polynomial x^5+x^2+1, preset all ones, sent inverted, high bit first), all LSB first. The CRC register must end at 5'b01100. A token of exactly three bytes that passes this check updates `tok_pid_o`, `tok_addr_o` and `tok_ep_o` and pulses `tok_valid_o` together with `pkt_done_o`.
- R9: A token that fails the CRC5 check reports `pkt_crc_err_o`=1, does not pulse `tok_valid_o`, and leaves the token outputs unchanged.
- R10: Each data payload byte is written once on `data_o` with a `data_we_o` pulse, in arrival order. The two CRC16 bytes are never written.
- R11: Data packets are checked with CRC16 (polynomial 0x8005, preset all ones, sent inverted, high bit first, residual 16'h800D). A mismatch reports `pkt_crc_err_o`=1 at the status pulse.
- R12: A packet during which `tx_active_i` is high raises no status pulse and no token update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | Received D+ level from the transceiver |
| dm_i | input | 1 | Received D- level from the transceiver |
| tx_active_i | input | 1 | Local transmitter is driving the bus |
| tok_valid_o | output | 1 | One-cycle pulse when a good token is promoted |
| tok_pid_o | output | 4 | PID of the live token |
| tok_addr_o | output | 7 | Device address of the live token |
| tok_ep_o | output | 4 | Endpoint number of the live token |
| data_o | output | 8 | Data payload byte |
| data_we_o | output | 1 | Write strobe for `data_o` |
| pkt_done_o | output | 1 | One-cycle status pulse at end of an accepted packet |
| pkt_kind_o | output | 2 | Packet kind of the status pulse |
| pkt_pid_o | output | 4 | PID of the status pulse |
| pkt_crc_err_o | output | 1 | CRC or length error of the status pulse |

## Verification
A wrong sampling phase or NRZI state shows up within one packet, as a missed sync or a corrupted PID: the expected status pulse is absent or its PID is wrong. A miscounted stuffing run shifts every later bit, which corrupts the payload words written out and flips the CRC verdict of the same packet. A broken staging path shows only at the token outputs. A bad-CRC token that changes them, or a good one that does not, is visible right after that packet's end.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    PKT_SPECIAL = 2'b00,
    PKT_TOKEN   = 2'b01,
    PKT_HSK     = 2'b10,
    PKT_DATA    = 2'b11
  } pkt_kind_e;

  localparam logic [4:0]  CRC5_RESIDUAL  = 5'b01100;
  localparam logic [15:0] CRC16_RESIDUAL = 16'h800D;
  localparam logic [4:0]  CRC5_POLY      = 5'h05;
  localparam logic [15:0] CRC16_POLY     = 16'h8005;
endpackage

// File: rtl/usb_rx_dpll.sv
module usb_rx_dpll #(
  parameter int OVS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic se0_o
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] SAMPLE_AT = CW'(OVS / 2);
  localparam logic [CW-1:0] LAST      = CW'(OVS - 1);

  logic [1:0] sync1_q, sync2_q, ls_q;
  logic [CW-1:0] ph_q;
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q   <= 2'b10;
      sync2_q   <= 2'b10;
      ls_q      <= 2'b10;
      ph_q      <= '0;
      lvl_q     <= 1'b1;
      bit_stb_o <= 1'b0;
      bit_o     <= 1'b1;
      se0_o     <= 1'b0;
    end else begin
      sync1_q   <= {dp_i, dm_i};
      sync2_q   <= sync1_q;
      ls_q      <= sync2_q;
      bit_stb_o <= 1'b0;
      // re-centre on every line change
      if (sync2_q != ls_q)   ph_q <= '0;
      else if (ph_q == LAST) ph_q <= '0;
      else                   ph_q <= ph_q + 1'b1;
      if (ph_q == SAMPLE_AT && sync2_q == ls_q) begin
        bit_stb_o <= 1'b1;
        se0_o     <= (ls_q == 2'b00);
        bit_o     <= (ls_q[1] == lvl_q);
        if (ls_q != 2'b00) lvl_q <= ls_q[1];
      end
    end
  end

  // R2
  strobe_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/usb_rx_bitproc.sv
module usb_rx_bitproc #(
  parameter int SYNC_ZEROS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic bit_i,
  input  logic se0_i,
  output logic sop_o,
  output logic bit_vld_o,
  output logic bit_o,
  output logic eop_o,
  output logic abort_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_EOP} bp_state_e;

  localparam logic [2:0] ZMAX = 3'd7;
  localparam logic [2:0] ZMIN = 3'(SYNC_ZEROS);

  bp_state_e st_q;
  logic [2:0] zeros_q, ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      zeros_q   <= '0;
      ones_q    <= '0;
      sop_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
      eop_o     <= 1'b0;
      abort_o   <= 1'b0;
    end else begin
      sop_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      eop_o     <= 1'b0;
      abort_o   <= 1'b0;
      if (stb_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (se0_i) zeros_q <= '0;
            else if (!bit_i) begin
              if (zeros_q != ZMAX) zeros_q <= zeros_q + 1'b1;
            end else if (zeros_q >= ZMIN) begin
              sop_o   <= 1'b1;
              st_q    <= ST_ACTIVE;
              ones_q  <= 3'd1;  // sync tail counts toward stuffing
              zeros_q <= '0;
            end else zeros_q <= '0;
          end
          ST_ACTIVE: begin
            if (se0_i) st_q <= ST_EOP;
            else if (ones_q == 3'd6) begin
              if (bit_i) begin
                abort_o <= 1'b1;
                st_q    <= ST_IDLE;
              end
              ones_q <= '0;
            end else begin
              bit_vld_o <= 1'b1;
              bit_o     <= bit_i;
              ones_q    <= bit_i ? ones_q + 1'b1 : 3'd0;
            end
          end
          default: begin
            if (!se0_i) begin
              eop_o <= 1'b1;
              st_q  <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  // R4
  ones_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'd6);
  // R5
  eop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);
endmodule

// File: rtl/usb_rx_pkt.sv
module usb_rx_pkt
  import usb_rx_pkg::*;
#(
  parameter int MAX_BYTES = 1030
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  input  logic       eop_i,
  input  logic       abort_i,
  input  logic       tx_active_i,
  output logic       tok_valid_o,
  output logic [3:0] tok_pid_o,
  output logic [6:0] tok_addr_o,
  output logic [3:0] tok_ep_o,
  output logic [7:0] data_o,
  output logic       data_we_o,
  output logic       pkt_done_o,
  output logic [1:0] pkt_kind_o,
  output logic [3:0] pkt_pid_o,
  output logic       pkt_crc_err_o
);
  localparam int NB_W = $clog2(MAX_BYTES + 4);
  localparam logic [NB_W-1:0] NB_MAX = '1;

  logic            live_q, drop_q;
  logic [2:0]      bcnt_q;
  logic [NB_W-1:0] nbytes_q;
  logic [7:0]      sh_q, pid_q, hold0_q, hold1_q;
  logic [15:0]     stage_q;
  logic [1:0]      fill_q;
  logic [4:0]      crc5_q;
  logic [15:0]     crc16_q;

  logic [7:0]  nxt_byte;
  logic [4:0]  crc5_nxt;
  logic [15:0] crc16_nxt;
  pkt_kind_e   kind;
  logic        good;

  always_comb begin
    nxt_byte  = {bit_i, sh_q[7:1]};
    crc5_nxt  = {crc5_q[3:0], 1'b0} ^ ((bit_i ^ crc5_q[4]) ? CRC5_POLY : 5'h00);
    crc16_nxt = {crc16_q[14:0], 1'b0} ^ ((bit_i ^ crc16_q[15]) ? CRC16_POLY : 16'h0000);
    kind      = pkt_kind_e'(pid_q[1:0]);
    unique case (kind)
      PKT_TOKEN: good = (bcnt_q == 3'd0) && (nbytes_q == NB_W'(3)) && (crc5_q == CRC5_RESIDUAL);
      PKT_DATA:  good = (bcnt_q == 3'd0) && (nbytes_q >= NB_W'(3)) && (crc16_q == CRC16_RESIDUAL);
      PKT_HSK:   good = (bcnt_q == 3'd0) && (nbytes_q == NB_W'(1));
      default:   good = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0; drop_q <= 1'b0; bcnt_q <= '0; nbytes_q <= '0;
      sh_q <= '0; pid_q <= '0; hold0_q <= '0; hold1_q <= '0; stage_q <= '0;
      fill_q <= '0; crc5_q <= '1; crc16_q <= '1;
      tok_valid_o <= 1'b0; tok_pid_o <= '0; tok_addr_o <= '0; tok_ep_o <= '0;
      data_o <= '0; data_we_o <= 1'b0;
      pkt_done_o <= 1'b0; pkt_kind_o <= '0; pkt_pid_o <= '0; pkt_crc_err_o <= 1'b0;
    end else begin
      tok_valid_o <= 1'b0;
      data_we_o   <= 1'b0;
      pkt_done_o  <= 1'b0;
      if (sop_i) begin
        live_q   <= 1'b1;
        drop_q   <= tx_active_i;
        bcnt_q   <= '0;
        nbytes_q <= '0;
        fill_q   <= '0;
        crc5_q   <= '1;
        crc16_q  <= '1;
      end else if (live_q) begin
        if (tx_active_i) drop_q <= 1'b1;
        if (abort_i) live_q <= 1'b0;
        else if (bit_vld_i) begin
          sh_q   <= nxt_byte;
          bcnt_q <= bcnt_q + 1'b1;
          if (nbytes_q != '0) begin
            crc5_q  <= crc5_nxt;
            crc16_q <= crc16_nxt;
          end
          if (bcnt_q == 3'd7) begin
            if (nbytes_q != NB_MAX) nbytes_q <= nbytes_q + 1'b1;
            if (nbytes_q == '0) begin
              pid_q <= nxt_byte;
              if (nxt_byte[7:4] != ~nxt_byte[3:0]) drop_q <= 1'b1;
            end else begin
              if (nbytes_q == NB_W'(1)) stage_q[7:0]  <= nxt_byte;
              if (nbytes_q == NB_W'(2)) stage_q[15:8] <= nxt_byte;
              // two-byte lag keeps the CRC16 bytes out of the stream
              if (kind == PKT_DATA && !drop_q) begin
                hold0_q <= nxt_byte;
                hold1_q <= hold0_q;
                if (fill_q == 2'd2) begin
                  data_we_o <= 1'b1;
                  data_o    <= hold1_q;
                end else fill_q <= fill_q + 1'b1;
              end
            end
          end
        end else if (eop_i) begin
          live_q <= 1'b0;
          if (!drop_q && nbytes_q != '0 && kind != PKT_SPECIAL) begin
            pkt_done_o    <= 1'b1;
            pkt_kind_o    <= pid_q[1:0];
            pkt_pid_o     <= pid_q[3:0];
            pkt_crc_err_o <= !good;
            if (kind == PKT_TOKEN && good) begin
              tok_valid_o <= 1'b1;
              tok_pid_o   <= pid_q[3:0];
              tok_addr_o  <= stage_q[6:0];
              tok_ep_o    <= stage_q[10:7];
            end
          end
        end
      end
    end
  end

  // R8
  tok_with_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o |-> (pkt_done_o && !pkt_crc_err_o && pkt_kind_o == 2'b01));
  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !pkt_done_o);
  // R6
  pid_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> (pid_q[7:4] == ~pid_q[3:0]));
  // R10
  write_data_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |-> (pid_q[1:0] == 2'b11 && !drop_q));
endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx #(
  parameter int OVS       = 4,
  parameter int MAX_BYTES = 1030
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       tx_active_i,
  output logic       tok_valid_o,
  output logic [3:0] tok_pid_o,
  output logic [6:0] tok_addr_o,
  output logic [3:0] tok_ep_o,
  output logic [7:0] data_o,
  output logic       data_we_o,
  output logic       pkt_done_o,
  output logic [1:0] pkt_kind_o,
  output logic [3:0] pkt_pid_o,
  output logic       pkt_crc_err_o
);
  logic stb, rx_bit, se0;
  logic sop, bvld, bval, eop, abort;

  usb_rx_dpll #(.OVS(OVS)) dpll_i (
    .clk_i, .rst_ni, .dp_i, .dm_i,
    .bit_stb_o(stb), .bit_o(rx_bit), .se0_o(se0)
  );

  usb_rx_bitproc #(.SYNC_ZEROS(5)) bitproc_i (
    .clk_i, .rst_ni, .stb_i(stb), .bit_i(rx_bit), .se0_i(se0),
    .sop_o(sop), .bit_vld_o(bvld), .bit_o(bval), .eop_o(eop), .abort_o(abort)
  );

  usb_rx_pkt #(.MAX_BYTES(MAX_BYTES)) pkt_i (
    .clk_i, .rst_ni, .sop_i(sop), .bit_vld_i(bvld), .bit_i(bval),
    .eop_i(eop), .abort_i(abort), .tx_active_i,
    .tok_valid_o, .tok_pid_o, .tok_addr_o, .tok_ep_o,
    .data_o, .data_we_o, .pkt_done_o, .pkt_kind_o, .pkt_pid_o, .pkt_crc_err_o
  );
endmodule

// File: tb/usb_fs_rx_tb_top.sv
module usb_fs_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1, dm = 1'b0, tx_act = 1'b0;
  logic tok_valid, data_we, pkt_done, pkt_crc_err;
  logic [3:0] tok_pid, tok_ep, pkt_pid;
  logic [6:0] tok_addr;
  logic [7:0] data;
  logic [1:0] pkt_kind;

  always #4 clk = ~clk;

  usb_fs_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .tx_active_i(tx_act),
    .tok_valid_o(tok_valid), .tok_pid_o(tok_pid), .tok_addr_o(tok_addr), .tok_ep_o(tok_ep),
    .data_o(data), .data_we_o(data_we), .pkt_done_o(pkt_done), .pkt_kind_o(pkt_kind),
    .pkt_pid_o(pkt_pid), .pkt_crc_err_o(pkt_crc_err)
  );

  int checks = 0, errors = 0;
  int done_cnt = 0, tok_cnt = 0, wr_cnt = 0;
  logic [7:0] wr_log [0:255];
  logic [1:0] last_kind;
  logic [3:0] last_pid;
  logic last_err;
  logic finished = 1'b0;

  always @(negedge clk) begin
    if (data_we) begin
      wr_log[wr_cnt[7:0]] <= data;
      wr_cnt <= wr_cnt + 1;
    end
    if (pkt_done) begin
      done_cnt  <= done_cnt + 1;
      last_kind <= pkt_kind;
      last_pid  <= pkt_pid;
      last_err  <= pkt_crc_err;
    end
    if (tok_valid) tok_cnt <= tok_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic raw [0:511];
  int nraw;

  task automatic add_bit(input logic b);
    raw[nraw] = b;
    nraw++;
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) add_bit(b[i]);
  endtask

  task automatic start_pkt(input logic [7:0] pid_byte);
    nraw = 0;
    add_byte(8'h80);  // sync
    add_byte(pid_byte);
  endtask

  task automatic add_crc5(input bit corrupt);
    logic [4:0] c = 5'h1f;
    for (int i = 16; i < nraw; i++)
      c = {c[3:0], 1'b0} ^ ((raw[i] ^ c[4]) ? 5'h05 : 5'h00);
    for (int i = 4; i >= 0; i--) add_bit(~c[i]);
    if (corrupt) raw[nraw-1] = ~raw[nraw-1];
  endtask

  task automatic add_crc16(input bit corrupt);
    logic [15:0] c = 16'hffff;
    for (int i = 16; i < nraw; i++)
      c = {c[14:0], 1'b0} ^ ((raw[i] ^ c[15]) ? 16'h8005 : 16'h0000);
    for (int i = 15; i >= 0; i--) add_bit(~c[i]);
    if (corrupt) raw[nraw-1] = ~raw[nraw-1];
  endtask

  task automatic drive_level(input logic j, input int clocks);
    @(negedge clk);
    dp = j; dm = ~j;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic transmit(input bit stuff_err, input bit jitter);
    logic lvl = 1'b1;
    int ones = 0, sent = 0;
    for (int i = 0; i < nraw; i++) begin
      if (!raw[i]) lvl = ~lvl;
      drive_level(lvl, (jitter && (sent % 8) == 7) ? 5 : 4);
      sent++;
      ones = raw[i] ? ones + 1 : 0;
      if (ones == 6) begin
        if (!stuff_err) lvl = ~lvl;
        drive_level(lvl, 4);
        sent++;
        ones = 0;
      end
    end
    @(negedge clk); dp = 1'b0; dm = 1'b0;
    repeat (7) @(negedge clk);
    drive_level(1'b1, 4);
    repeat (64) @(negedge clk);
  endtask

  task automatic send_token(input logic [3:0] pid, input logic [6:0] addr,
                            input logic [3:0] ep, input bit bad, input bit jit);
    start_pkt({~pid, pid});
    for (int i = 0; i < 7; i++) add_bit(addr[i]);
    for (int i = 0; i < 4; i++) add_bit(ep[i]);
    add_crc5(bad);
    transmit(1'b0, jit);
  endtask

  task automatic test_reset;
    chk(tok_valid == 0 && data_we == 0 && pkt_done == 0, "R1 strobes", {tok_valid, data_we, pkt_done}, 0);
    chk(tok_addr == 0 && tok_ep == 0 && tok_pid == 0, "R1 token", tok_addr, 0);
    chk(pkt_kind == 0 && pkt_pid == 0 && pkt_crc_err == 0 && data == 0, "R1 status", pkt_pid, 0);
  endtask

  task automatic test_good_token;
    int d0 = done_cnt, t0 = tok_cnt;
    send_token(4'b0001, 7'h05, 4'h3, 1'b0, 1'b0);
    chk(done_cnt == d0 + 1, "R5 one status pulse", done_cnt - d0, 1);
    chk(last_kind == 2'b01 && last_pid == 4'b0001, "R7 token kind/pid", {last_kind, last_pid}, 6'b010001);
    chk(last_err == 0, "R8 no crc error", last_err, 0);
    chk(tok_cnt == t0 + 1, "R8 tok_valid", tok_cnt - t0, 1);
    chk(tok_addr == 7'h05 && tok_ep == 4'h3 && tok_pid == 4'b0001, "R8 token fields",
        {tok_pid, tok_addr, tok_ep}, {4'b0001, 7'h05, 4'h3});
  endtask

  task automatic test_bad_token;
    int d0 = done_cnt, t0 = tok_cnt;
    send_token(4'b1001, 7'h44, 4'hA, 1'b1, 1'b0);
    chk(done_cnt == d0 + 1 && last_err == 1, "R9 crc error flagged", last_err, 1);
    chk(tok_cnt == t0, "R9 no tok_valid", tok_cnt - t0, 0);
    chk(tok_addr == 7'h05 && tok_ep == 4'h3, "R9 token unchanged", tok_addr, 5);
  endtask

  task automatic test_jitter_token;
    int t0 = tok_cnt;
    send_token(4'b1101, 7'h2A, 4'h9, 1'b0, 1'b1);
    chk(tok_cnt == t0 + 1 && tok_addr == 7'h2A && tok_ep == 4'h9, "R2 stretched bits", tok_addr, 42);
  endtask

  task automatic test_data(input bit corrupt);
    logic [7:0] pl [0:4];
    int d0 = done_cnt, w0 = wr_cnt;
    pl[0] = 8'h00; pl[1] = 8'hFF; pl[2] = 8'hFF; pl[3] = 8'h5A; pl[4] = 8'h81;
    start_pkt(8'hC3);
    for (int i = 0; i < 5; i++) add_byte(pl[i]);
    add_crc16(corrupt);
    transmit(1'b0, 1'b0);
    chk(wr_cnt - w0 == 5, "R10 write count", wr_cnt - w0, 5);
    for (int i = 0; i < 5; i++)
      chk(wr_log[8'(w0 + i)] == pl[i], "R4 R10 payload byte", wr_log[8'(w0 + i)], pl[i]);
    chk(done_cnt == d0 + 1 && last_kind == 2'b11, "R7 data kind", last_kind, 3);
    chk(last_err == corrupt, "R11 crc16 verdict", last_err, corrupt);
  endtask

  task automatic test_handshake;
    int d0 = done_cnt;
    start_pkt(8'hD2);
    transmit(1'b0, 1'b0);
    chk(done_cnt == d0 + 1 && last_kind == 2'b10 && last_pid == 4'b0010 && last_err == 0,
        "R7 handshake", {last_kind, last_pid}, 6'b100010);
  endtask

  task automatic test_bad_pid;
    int d0 = done_cnt, w0 = wr_cnt;
    start_pkt(8'h33);
    add_byte(8'h12); add_byte(8'h34);
    add_crc16(1'b0);
    transmit(1'b0, 1'b0);
    chk(done_cnt == d0 && wr_cnt == w0, "R6 malformed pid ignored", done_cnt - d0, 0);
  endtask

  task automatic test_own_tx;
    int d0 = done_cnt, t0 = tok_cnt;
    tx_act = 1'b1;
    send_token(4'b0001, 7'h11, 4'h1, 1'b0, 1'b0);
    tx_act = 1'b0;
    chk(done_cnt == d0 && tok_cnt == t0 && tok_addr == 7'h2A, "R12 own packet dropped", done_cnt - d0, 0);
  endtask

  task automatic test_stuff_err;
    int d0 = done_cnt, w0 = wr_cnt;
    start_pkt(8'hC3);
    add_byte(8'hFF); add_byte(8'hFF);
    add_crc16(1'b0);
    transmit(1'b1, 1'b0);
    chk(done_cnt == d0 && wr_cnt == w0, "R4 stuff error aborts", done_cnt - d0, 0);
    chk(tok_addr == 7'h2A, "R4 token unchanged", tok_addr, 42);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    test_good_token();
    test_bad_token();
    test_jitter_token();
    test_data(1'b0);
    test_data(1'b1);
    test_handshake();
    test_bad_pid();
    test_own_tx();
    test_stuff_err();
    test_handshake();  // R3 receiver resynchronises after an abort
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule